// File: doc/BRIEF.md
# Byte-Lane Controller for an Asynchronous Static RAM

This block connects a simple single-request port inside a synchronous design to an external static RAM that has no clock and gives no ready signal. The default memory holds 262,144 words of 16 bits. A client pulses a request with a write flag, an 18-bit word address, write data and a per-byte mask. The controller then drives the memory's active-low chip enable, output enable, write enable and per-byte strobes, plus a shared three-state data bus. It returns a one-cycle done pulse and, for reads, a registered copy of the word.

Access timing comes from counting clock cycles only. The strobe-active window lasts WAIT = max(2, ceil(ACCESS_NS / CLK_NS) + 1) cycles, so the same logic serves a faster or a slower speed grade through a parameter. Between accesses the memory sits in its low-power standby state, and at least one fully idle cycle separates two accesses.

Top module: `sram_byte_ctrl`

## Requirements
- R1: During reset and whenever no access is in progress, mem_ce_n_o, mem_oe_n_o, mem_we_n_o and both bits of mem_be_n_o are 1 and done_o is 0.
- R2: A write (wr_i=1) accepted at a clock edge drives mem_ce_n_o=0 from the next cycle on. In the first such cycle address, data and strobes are valid with mem_we_n_o=1. Then mem_we_n_o is 0 for WAIT cycles. Then comes one more cycle with mem_we_n_o=1, mem_ce_n_o=0 and the data still driven.
- R3: WAIT = max(2, ceil(ACCESS_NS/CLK_NS)+1). With the defaults (CLK_NS=10, ACCESS_NS=70) this is 8 cycles of mem_we_n_o low.
- R4: A read (wr_i=0) accepted at a clock edge drives mem_ce_n_o=0 and mem_oe_n_o=0 with mem_we_n_o=1, the address and the strobes for exactly WAIT cycles, starting the next cycle.
- R5: Read data is sampled from the bus at the end of the last cycle with mem_oe_n_o low. It appears on rdata_o with unselected bytes forced to 0 and holds until the next read completes.
- R6: mask_i bit 0 selects bits 7:0 and drives mem_be_n_o[0] low; bit 1 selects bits 15:8 and drives mem_be_n_o[1] low. A write changes only the selected bytes of the addressed word.
- R7: A request with mask_i=00 raises done_o in the next cycle and causes no strobe activity on the memory pins.
- R8: done_o is a one-cycle pulse in the cycle after the last active memory cycle, with all memory controls at 1. A new request is accepted at the earliest in that done cycle, which gives at least one idle cycle between accesses.
- R9: A request presented while an access is in progress is ignored.
- R10: The controller drives the data bus only while mem_oe_n_o is 1, and releases it for the whole read window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request, sampled when idle or in the done cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| mask_i | input | 2 | Byte select, bit 0 low byte, bit 1 high byte |
| rdata_o | output | 16 | Registered read data |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 18 | Memory address bus |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_be_n_o | output | 2 | Byte strobes, active low, bit 0 low byte |
| mem_dq_io | inout | 16 | Three-state data bus |

## Verification
The bench writes a full word, then patches single bytes of it and reads it back through each mask. A controller with swapped lanes or unmasked writes would return the wrong word, and one that did not zero unselected lanes would leak stale bits into rdata_o. A zero-mask request, a request raised in the middle of a read, and a request raised exactly in the done cycle check the edges of acceptance. Getting these wrong would show up as spurious strobes, a corrupted word, or a missing idle cycle. The bench counts the write-enable low time against the WAIT formula, which catches an off-by-one in the wait counter.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and the wait-cycle calculation for the static RAM controller.
// Assumes integer nanosecond timing parameters.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WRECOV,
        ST_RWAIT,
        ST_GAP
    } seq_state_t;

    // Strobe window length: ceil(access/clock) plus one margin cycle, at least two.
    function automatic int wait_cycles(input int access_ns, input int clk_ns);
        int c;
        c = (access_ns + clk_ns - 1) / clk_ns + 1;
        return (c < 2) ? 2 : c;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that times the strobe window.
// Assumes: load is raised in the cycle before the window starts; expired_o is
// high in the last cycle of the window (WAIT cycles after load).
module sram_wait_timer #(
    parameter int WAIT  = 8,
    localparam int CNT_W = (WAIT > 2) ? $clog2(WAIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= CNT_W'(WAIT - 1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    AST_TIMER_NOT_EXPIRED_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expired_o);  // R3
endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer: accepts a request when idle or in the done cycle, then
// steps through the write or read phases. Assumes the timer reports expiry
// in the last cycle of each strobe window.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       wr_i,
    input  logic       mask_nz_i,
    input  logic       expired_i,
    output seq_state_t state_o,
    output logic       accept_o,
    output logic       load_o,
    output logic       capture_o
);
    seq_state_t state_q, state_d;
    logic       ready;

    assign ready    = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign accept_o = ready && req_i;
    assign load_o   = (accept_o && mask_nz_i && !wr_i) || (state_q == ST_WSETUP);
    assign capture_o = (state_q == ST_RWAIT) && expired_i;

    // Next-state selection for both access kinds.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE, ST_GAP: begin
                if (accept_o) begin
                    if (!mask_nz_i) state_d = ST_GAP;
                    else if (wr_i)  state_d = ST_WSETUP;
                    else            state_d = ST_RWAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WSETUP: state_d = ST_WPULSE;
            ST_WPULSE: if (expired_i) state_d = ST_WRECOV;
            ST_WRECOV: state_d = ST_GAP;
            ST_RWAIT:  if (expired_i) state_d = ST_GAP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    AST_ZERO_MASK_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !mask_nz_i) |=> (state_q == ST_GAP));  // R7
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WSETUP) |=> (state_q == ST_WPULSE));  // R9
endmodule

// File: rtl/sram_lane_regs.sv
// Request latch and read capture. Latches address, data and mask on accept;
// samples the bus on capture with unselected byte lanes forced to zero.
module sram_lane_regs #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  mask_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [LANES-1:0]  mask_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] lane_keep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_keep[g*8 +: 8] = {8{mask_o[g]}};
    end

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o  <= '0;
            wdata_o <= '0;
            mask_o  <= '0;
        end else if (accept_i) begin
            addr_o  <= addr_i;
            wdata_o <= wdata_i;
            mask_o  <= mask_i;
        end
    end

    // Sample the memory bus at the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_o <= '0;
        else if (capture_i) rdata_o <= bus_i & lane_keep;
    end
endmodule

// File: rtl/sram_byte_ctrl.sv
// Top of the static RAM controller. Decodes memory pins from the sequencer
// state and owns the three-state data bus. Assumes one external memory whose
// access time is covered by WAIT clock cycles.
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int CLK_NS    = 10,
    parameter int ACCESS_NS = 70,
    localparam int LANES    = DATA_W / 8,
    localparam int WAIT     = wait_cycles(ACCESS_NS, CLK_NS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  mask_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_ce_n_o,
    output logic              mem_oe_n_o,
    output logic              mem_we_n_o,
    output logic [LANES-1:0]  mem_be_n_o,
    inout  wire  [DATA_W-1:0] mem_dq_io
);
    seq_state_t        state;
    logic              accept, load, capture, expired, drive_en;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;

    sram_seq_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wr_i      (wr_i),
        .mask_nz_i (|mask_i),
        .expired_i (expired),
        .state_o   (state),
        .accept_o  (accept),
        .load_o    (load),
        .capture_o (capture)
    );

    sram_wait_timer #(.WAIT(WAIT)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .expired_o (expired)
    );

    sram_lane_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .capture_i (capture),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .mask_i    (mask_i),
        .bus_i     (mem_dq_io),
        .addr_o    (mem_addr_o),
        .wdata_o   (wdata_q),
        .mask_o    (mask_q),
        .rdata_o   (rdata_o)
    );

    // Pin decode from the registered sequencer state (glitch-free levels).
    always_comb begin
        mem_ce_n_o = !(state inside {ST_WSETUP, ST_WPULSE, ST_WRECOV, ST_RWAIT});
        mem_we_n_o = (state != ST_WPULSE);
        mem_oe_n_o = (state != ST_RWAIT);
        drive_en   = state inside {ST_WSETUP, ST_WPULSE, ST_WRECOV};
        done_o     = (state == ST_GAP);
        mem_be_n_o = mem_ce_n_o ? '1 : ~mask_q;
    end

    assign mem_dq_io = drive_en ? wdata_q : 'z;

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> mem_oe_n_o);  // R10
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !mem_ce_n_o);  // R2
    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> $past(!mem_ce_n_o));  // R2
    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n_o && !mem_we_n_o));  // R4
    AST_DONE_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_ce_n_o && mem_oe_n_o && mem_we_n_o && (&mem_be_n_o)));  // R8
    AST_PINS_STABLE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_be_n_o)));  // R6
    AST_STANDBY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (mem_ce_n_o && (&mem_be_n_o) && !done_o));  // R1
endmodule

// File: tb/test_sram_byte_ctrl.sv
module test_sram_byte_ctrl;
    localparam int TB_CLK_NS = 10;
    localparam int ACC_NS    = 70;
    localparam int EW_RAW    = (ACC_NS + TB_CLK_NS - 1) / TB_CLK_NS + 1;
    localparam int EW        = (EW_RAW < 2) ? 2 : EW_RAW;

    logic        clk = 0, rst_n = 0;
    logic        req = 0, wr = 0;
    logic [17:0] addr = 0;
    logic [15:0] wdata = 0;
    logic [1:0]  mask = 0;
    logic [15:0] rdata;
    logic        done;
    logic [17:0] mem_addr;
    logic        ce_n, oe_n, we_n;
    logic [1:0]  be_n;
    wire  [15:0] dq;

    int checks = 0, fails = 0, cycles = 0;

    sram_byte_ctrl #(.CLK_NS(TB_CLK_NS), .ACCESS_NS(ACC_NS)) i_sram_byte_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
        .wdata_i(wdata), .mask_i(mask), .rdata_o(rdata), .done_o(done),
        .mem_addr_o(mem_addr), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n),
        .mem_we_n_o(we_n), .mem_be_n_o(be_n), .mem_dq_io(dq));

    always #(TB_CLK_NS/2) clk = ~clk;

    // ---------------- memory device model ----------------
    logic [15:0] dev [logic [17:0]];
    logic [15:0] dev_word;
    always_comb dev_word = dev.exists(mem_addr) ? dev[mem_addr] : 16'h0;
    assign dq[7:0]  = (!ce_n && !oe_n && we_n && !be_n[0]) ? dev_word[7:0]  : 8'hzz;
    assign dq[15:8] = (!ce_n && !oe_n && we_n && !be_n[1]) ? dev_word[15:8] : 8'hzz;

    always @(posedge clk) begin
        logic [15:0] w;
        if (!ce_n && !we_n) begin
            w = dev.exists(mem_addr) ? dev[mem_addr] : 16'h0;
            if (!be_n[0]) w[7:0]  = dq[7:0];
            if (!be_n[1]) w[15:8] = dq[15:8];
            dev[mem_addr] = w;
        end
    end

    // ---------------- reference model ----------------
    // kind: 0 idle, 1 write, 2 read, 3 done cycle
    int          m_kind = 0, m_step = 0;
    logic [17:0] m_addr = 0;
    logic [15:0] m_wdata = 0, m_rdata = 0;
    logic [1:0]  m_mask = 0;
    logic [15:0] shadow [logic [17:0]];
    bit          armed = 0;

    function automatic logic [15:0] expand(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    always @(posedge clk) begin
        logic [15:0] s;
        if (!rst_n) begin
            m_kind = 0; m_step = 0; m_rdata = 0; armed = 1;
        end else begin
            case (m_kind)
                0, 3: begin
                    if (req) begin
                        if (mask == 2'b00) m_kind = 3;
                        else begin
                            m_addr = addr; m_wdata = wdata; m_mask = mask; m_step = 1;
                            if (wr) begin
                                m_kind = 1;
                                s = shadow.exists(addr) ? shadow[addr] : 16'h0;
                                s = (s & ~expand(mask)) | (wdata & expand(mask));
                                shadow[addr] = s;
                            end else m_kind = 2;
                        end
                    end else m_kind = 0;
                end
                1: if (m_step == EW + 2) m_kind = 3; else m_step++;
                2: if (m_step == EW) begin
                       s = shadow.exists(m_addr) ? shadow[m_addr] : 16'h0;
                       m_rdata = s & expand(m_mask);
                       m_kind = 3;
                   end else m_step++;
                default: m_kind = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        string t;
        logic ex_we;
        if (armed) begin
            cycles++;
            t = (m_kind == 1) ? "R2" : (m_kind == 2) ? "R4" : (m_kind == 3) ? "R8" : "R1";
            ex_we = !(m_kind == 1 && m_step >= 2 && m_step <= EW + 1);
            chk(t, {31'b0, ce_n}, {31'b0, !(m_kind == 1 || m_kind == 2)});
            chk(t, {31'b0, oe_n}, {31'b0, !(m_kind == 2)});
            chk(t, {31'b0, we_n}, {31'b0, ex_we});
            chk("R6", {30'b0, be_n}, (m_kind == 1 || m_kind == 2) ? {30'b0, ~m_mask} : 32'h3);
            chk("R8", {31'b0, done}, {31'b0, (m_kind == 3)});
            chk("R5", {16'b0, rdata}, {16'b0, m_rdata});
            if (m_kind == 1 || m_kind == 2) chk(t, {14'b0, mem_addr}, {14'b0, m_addr});
            if (m_kind == 1) chk("R6", {16'b0, dq & expand(m_mask)}, {16'b0, m_wdata & expand(m_mask)});
            if (m_kind == 2) chk("R10", {16'b0, dq & expand(m_mask)},
                                 {16'b0, (shadow.exists(m_addr) ? shadow[m_addr] : 16'h0) & expand(m_mask)});
        end
    end

    // R3: measure write-enable low time directly.
    int we_low = 0;
    always @(negedge clk) begin
        if (armed && rst_n) begin
            if (!we_n) we_low++;
            else if (we_low != 0) begin
                chk("R3", we_low, EW);
                chk("R3", EW, 8);
                we_low = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input logic w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        req = 1; wr = w; addr = a; wdata = d; mask = m;
        @(negedge clk);
        req = 0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic access(input logic w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        send(w, a, d, m);
        wait_done();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {27'b0, ce_n, oe_n, we_n, be_n}, 32'h1F);
        rst_n = 1;
        @(negedge clk);
        chk("R1", {31'b0, done}, 0);

        access(1, 18'h00010, 16'hA55A, 2'b11);              // R2 full write
        access(0, 18'h00010, 16'h0, 2'b11);                 // R4 read
        chk("R5", rdata, 16'hA55A);
        access(1, 18'h00010, 16'h1234, 2'b01);              // R6 low byte patch
        access(0, 18'h00010, 16'h0, 2'b11);
        chk("R6", rdata, 16'hA534);
        access(1, 18'h3FFFF, 16'hBEEF, 2'b10);              // R6 high byte, top address
        access(0, 18'h3FFFF, 16'h0, 2'b11);
        chk("R6", rdata, 16'hBE00);
        access(0, 18'h00010, 16'h0, 2'b10);                 // R5 lane zeroing
        chk("R5", rdata, 16'hA500);

        send(1, 18'h00010, 16'hFFFF, 2'b00);                // R7 zero mask
        chk("R7", {30'b0, done, ce_n}, 32'h3);
        @(negedge clk);
        access(0, 18'h00010, 16'h0, 2'b11);
        chk("R7", rdata, 16'hA534);

        send(0, 18'h00010, 16'h0, 2'b11);                   // R9 request while busy
        @(negedge clk);
        send(1, 18'h00010, 16'h0000, 2'b11);
        wait_done();
        @(negedge clk);
        access(0, 18'h00010, 16'h0, 2'b11);
        chk("R9", rdata, 16'hA534);

        send(1, 18'h00020, 16'h5AA5, 2'b11);                // R8 request in done cycle
        wait_done();
        send(0, 18'h00020, 16'h0, 2'b11);
        chk("R8", {31'b0, ce_n}, 0);
        wait_done();
        chk("R8", rdata, 16'h5AA5);
        @(negedge clk);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule